// File: doc/BRIEF.md
# Storage Set-Features Command Handler

This block decodes and carries out the configuration command that a host sends to an ATA-style storage device to change its operating features. Each command arrives as a one-cycle strobe with a subcommand code and a count byte. The block holds the device configuration: 8-bit data transfer, write cache, the selected PIO mode, the selected DMA mode and its kind (Multiword or Ultra), IORDY disable, and the power management level. It exports these settings to the transfer engines and the bus interface.

Every command it executes ends in a single-cycle done pulse or a single-cycle abort pulse. An aborted command changes nothing. A request to turn the write cache off first asks a cache controller to write its contents back to non-volatile storage. Completion waits for the controller's acknowledge. The block ignores new strobes while it waits.

Top module: `setfeat_handler`

## Requirements
- R1: After reset the state is: PIO mode 0, IORDY on, write cache on, 8-bit mode off, `io16_en` high, power level FEh, Multiword DMA mode 0 selected with `mdma_on`=1 and `udma_on`=0, `dma_active`=0, and no status pulse.
- R2: Subcommand 01h turns 8-bit mode on and subcommand 81h turns it off. `io16_en` is low exactly while 8-bit mode is on.
- R3: Subcommand 02h turns the write cache on and completes at once.
- R4: Subcommand 82h raises `flush_req` and `busy` on the clock after the strobe. Both stay high until `flush_ack` is sampled high. On that edge `flush_req` and `busy` drop, `wcache_on` falls and `cmd_done` pulses. A strobe accepted while `busy` is high produces no status pulse and changes no state.
- R5: Subcommand 03h reads count bits 7:3 as a transfer type and bits 2:0 as a mode number n. Type 00001b with n <= PIO_MAX sets `pio_mode`=n, sets `dma_active`=0 and keeps the IORDY-disable setting.
- R6: Subcommand 03h with count 00h sets PIO mode 0, clears `dma_active` and enables IORDY. Count 01h sets PIO mode 0, clears `dma_active` and disables IORDY when IORDY_OFF_OK=1; when IORDY_OFF_OK=0 it aborts.
- R7: Type 00100b with n <= MDMA_MAX selects Multiword DMA mode n (`mdma_on`=1, `udma_on`=0). Type 01000b with n <= UDMA_MAX selects Ultra DMA mode n (`udma_on`=1, `mdma_on`=0). Either choice sets `dma_active`=1 and `dma_mode`=n.
- R8: `iordy_on` is high whenever `pio_mode` >= 3, even when IORDY has been disabled.
- R9: Subcommand 05h loads the count byte into `apm_level`. The counts 00h and FFh abort.
- R10: The following abort and leave all state unchanged: a mode number above the maximum for its type, a type code other than 00000b, 00001b, 00100b or 01000b, type 00000b with n > 1, and any subcommand other than 01h, 81h, 02h, 82h, 03h or 05h.
- R11: Subcommand 01h aborts while `dma_active` is high.
- R12: Each accepted strobe yields exactly one of `cmd_done` or `cmd_abort`, high for a single cycle. For all subcommands except 82h the pulse appears on the clock edge that samples the strobe. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_sub | input | 8 | Subcommand code |
| cmd_count | input | 8 | Count byte (mode or level argument) |
| flush_ack | input | 1 | Cache controller reports that write-back has finished |
| cmd_done | output | 1 | Command completed |
| cmd_abort | output | 1 | Command rejected |
| busy | output | 1 | Waiting for a cache write-back |
| flush_req | output | 1 | Write-back request to the cache controller |
| xfer8_on | output | 1 | 8-bit data transfer enabled |
| io16_en | output | 1 | 16-bit indication allowed for data register accesses |
| wcache_on | output | 1 | Write cache enabled |
| pio_mode | output | 3 | Selected PIO mode |
| iordy_on | output | 1 | IORDY flow control in use |
| mdma_on | output | 1 | Multiword DMA is the selected DMA kind |
| udma_on | output | 1 | Ultra DMA is the selected DMA kind |
| dma_mode | output | 3 | Selected DMA mode number |
| dma_active | output | 1 | DMA, rather than PIO, is the active transfer method |
| apm_level | output | 8 | Power management level |

## Verification
A table of commands runs through the mode byte's type and number fields. It covers every legal type at its top supported number and one number past it, the two reserved type patterns, and both special default-PIO counts. This separates a bound check that is off by one from a type decode that lets reserved codes through. The sequence moves from Multiword to Ultra DMA and back again, and toggles IORDY disable across PIO modes 2 and 3. These steps expose a DMA kind that is not exclusive and an IORDY override placed at the wrong threshold. Directed tests cover the reset values, a write-back that is held for several cycles with a strobe that must be ignored meanwhile, and the power level boundaries 00h, 01h, 80h and FFh.

// File: rtl/setfeat_pkg.sv
// Package: codes and decoded-command record shared by the Set Features handler.
// Assumes 8-bit subcommand and count fields as seen at the handler's ports.
package setfeat_pkg;

    localparam logic [7:0] SUB_X8_ON  = 8'h01;
    localparam logic [7:0] SUB_X8_OFF = 8'h81;
    localparam logic [7:0] SUB_WC_ON  = 8'h02;
    localparam logic [7:0] SUB_WC_OFF = 8'h82;
    localparam logic [7:0] SUB_XFER   = 8'h03;
    localparam logic [7:0] SUB_POWER  = 8'h05;

    localparam logic [4:0] TYP_PIO_DEF  = 5'b00000;
    localparam logic [4:0] TYP_PIO_FLOW = 5'b00001;
    localparam logic [4:0] TYP_MDMA     = 5'b00100;
    localparam logic [4:0] TYP_UDMA     = 5'b01000;

    localparam logic [7:0] LEVEL_RSV_LO = 8'h00;
    localparam logic [7:0] LEVEL_RSV_HI = 8'hFF;
    localparam logic [7:0] LEVEL_RESET  = 8'hFE;

    typedef enum logic [2:0] {
        ACT_X8_ON,
        ACT_X8_OFF,
        ACT_WC_ON,
        ACT_WC_OFF,
        ACT_PIO,
        ACT_DMA,
        ACT_POWER,
        ACT_NONE
    } sf_act_e;

    typedef struct packed {
        logic       ok;        // command is legal in the current state
        sf_act_e    act;       // what to change
        logic [2:0] mode;      // PIO or DMA mode number
        logic       iordy_wr;  // PIO action rewrites the IORDY-disable flag
        logic       iordy_off; // new IORDY-disable value
        logic       ultra;     // DMA action picks Ultra rather than Multiword
        logic [7:0] level;     // power level for ACT_POWER
    } sf_dec_t;

endpackage

// File: rtl/setfeat_decode.sv
// Module: combinational decode and legality check of one command.
// Assumes the caller applies the result only when dec.ok is set; the
// maximum mode numbers fit in three bits.
module setfeat_decode
    import setfeat_pkg::*;
#(
    parameter int PIO_MAX      = 4,
    parameter int MDMA_MAX     = 2,
    parameter int UDMA_MAX     = 5,
    parameter bit DMA_OK       = 1'b1,
    parameter bit IORDY_OFF_OK = 1'b1
) (
    input  logic [7:0] sub,
    input  logic [7:0] count,
    input  logic       dma_active,
    output sf_dec_t    dec
);
    localparam logic [2:0] PIO_TOP  = 3'(PIO_MAX);
    localparam logic [2:0] MDMA_TOP = 3'(MDMA_MAX);
    localparam logic [2:0] UDMA_TOP = 3'(UDMA_MAX);

    logic [4:0] typ;
    logic [2:0] num;

    assign typ = count[7:3];
    assign num = count[2:0];

    // Map subcommand plus count onto one action and its legality.
    always_comb begin
        dec           = '0;
        dec.act       = ACT_NONE;
        dec.mode      = num;
        dec.level     = count;
        unique case (sub)
            SUB_X8_ON: begin
                dec.act = ACT_X8_ON;
                dec.ok  = !dma_active;
            end
            SUB_X8_OFF: begin
                dec.act = ACT_X8_OFF;
                dec.ok  = 1'b1;
            end
            SUB_WC_ON: begin
                dec.act = ACT_WC_ON;
                dec.ok  = 1'b1;
            end
            SUB_WC_OFF: begin
                dec.act = ACT_WC_OFF;
                dec.ok  = 1'b1;
            end
            SUB_XFER: begin
                unique case (typ)
                    TYP_PIO_DEF: begin
                        dec.act       = ACT_PIO;
                        dec.mode      = 3'd0;
                        dec.iordy_wr  = 1'b1;
                        dec.iordy_off = (num == 3'd1);
                        dec.ok        = (num == 3'd0) || ((num == 3'd1) && IORDY_OFF_OK);
                    end
                    TYP_PIO_FLOW: begin
                        dec.act = ACT_PIO;
                        dec.ok  = (num <= PIO_TOP);
                    end
                    TYP_MDMA: begin
                        dec.act = ACT_DMA;
                        dec.ok  = DMA_OK && (num <= MDMA_TOP);
                    end
                    TYP_UDMA: begin
                        dec.act   = ACT_DMA;
                        dec.ultra = 1'b1;
                        dec.ok    = DMA_OK && (num <= UDMA_TOP);
                    end
                    default: dec.ok = 1'b0;
                endcase
            end
            SUB_POWER: begin
                dec.act = ACT_POWER;
                dec.ok  = (count != LEVEL_RSV_LO) && (count != LEVEL_RSV_HI);
            end
            default: dec.ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/setfeat_flush_seq.sv
// Module: write-back handshake for the cache-disable command.
// Assumes start is raised only while idle; the controller keeps flush_ack
// low until it has seen flush_req.
module setfeat_flush_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic flush_ack,
    output logic flush_req,
    output logic busy,
    output logic drain_done
);
    logic waiting_q;

    // Hold the request from start until the acknowledge is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiting_q <= 1'b0;
        else if (start)
            waiting_q <= 1'b1;
        else if (waiting_q && flush_ack)
            waiting_q <= 1'b0;
    end

    assign flush_req  = waiting_q;
    assign busy       = waiting_q;
    assign drain_done = waiting_q && flush_ack;

    // R4
    property flush_hold_p;
        @(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req;
    endproperty
    flush_hold_chk: assert property (flush_hold_p);

endmodule

// File: rtl/setfeat_state.sv
// Module: configuration registers of the device, updated by decoded actions.
// Assumes apply is raised only for legal, non-cache-disable commands;
// wc_clear marks the end of a write-back.
module setfeat_state
    import setfeat_pkg::*;
#(
    parameter bit DMA_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply,
    input  sf_dec_t    dec,
    input  logic       wc_clear,
    output logic       xfer8_on,
    output logic       wcache_on,
    output logic [2:0] pio_mode,
    output logic       iordy_on,
    output logic       mdma_on,
    output logic       udma_on,
    output logic [2:0] dma_mode,
    output logic       dma_active,
    output logic [7:0] apm_level
);
    localparam logic [2:0] IORDY_FORCE_MODE = 3'd3;

    logic       x8_q, wc_q, iordy_off_q, ultra_q, dact_q;
    logic [2:0] pio_q, dmode_q;
    logic [7:0] level_q;

    // 8-bit transfer flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            x8_q <= 1'b0;
        else if (apply && dec.act == ACT_X8_ON)
            x8_q <= 1'b1;
        else if (apply && dec.act == ACT_X8_OFF)
            x8_q <= 1'b0;
    end

    // Write cache flag: set directly, cleared only after the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wc_q <= 1'b1;
        else if (wc_clear)
            wc_q <= 1'b0;
        else if (apply && dec.act == ACT_WC_ON)
            wc_q <= 1'b1;
    end

    // PIO mode, IORDY-disable flag and active transfer method.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pio_q       <= 3'd0;
            iordy_off_q <= 1'b0;
            dact_q      <= 1'b0;
        end else if (apply && dec.act == ACT_PIO) begin
            pio_q  <= dec.mode;
            dact_q <= 1'b0;
            if (dec.iordy_wr)
                iordy_off_q <= dec.iordy_off;
        end else if (apply && dec.act == ACT_DMA) begin
            dact_q <= 1'b1;
        end
    end

    // DMA kind and mode: one field, so only one kind can be selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ultra_q <= 1'b0;
            dmode_q <= 3'd0;
        end else if (apply && dec.act == ACT_DMA) begin
            ultra_q <= dec.ultra;
            dmode_q <= dec.mode;
        end
    end

    // Power management level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= LEVEL_RESET;
        else if (apply && dec.act == ACT_POWER)
            level_q <= dec.level;
    end

    assign xfer8_on   = x8_q;
    assign wcache_on  = wc_q;
    assign pio_mode   = pio_q;
    assign iordy_on   = !iordy_off_q || (pio_q >= IORDY_FORCE_MODE);
    assign mdma_on    = DMA_OK && !ultra_q;
    assign udma_on    = DMA_OK && ultra_q;
    assign dma_mode   = dmode_q;
    assign dma_active = dact_q;
    assign apm_level  = level_q;

endmodule

// File: rtl/setfeat_handler.sv
// Module: top of the Set Features handler. Accepts one command strobe,
// decodes it, updates the configuration or starts a write-back, and
// reports a single-cycle done or abort pulse.
// Assumes cmd_valid is a one-cycle strobe; strobes while busy are dropped.
module setfeat_handler
    import setfeat_pkg::*;
#(
    parameter int PIO_MAX      = 4,
    parameter int MDMA_MAX     = 2,
    parameter int UDMA_MAX     = 5,
    parameter bit DMA_OK       = 1'b1,
    parameter bit IORDY_OFF_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_sub,
    input  logic [7:0] cmd_count,
    input  logic       flush_ack,
    output logic       cmd_done,
    output logic       cmd_abort,
    output logic       busy,
    output logic       flush_req,
    output logic       xfer8_on,
    output logic       io16_en,
    output logic       wcache_on,
    output logic [2:0] pio_mode,
    output logic       iordy_on,
    output logic       mdma_on,
    output logic       udma_on,
    output logic [2:0] dma_mode,
    output logic       dma_active,
    output logic [7:0] apm_level
);
    sf_dec_t dec;
    logic    accept, start_flush, apply, drain_done;
    logic    done_q, abort_q;

    setfeat_decode #(
        .PIO_MAX(PIO_MAX), .MDMA_MAX(MDMA_MAX), .UDMA_MAX(UDMA_MAX),
        .DMA_OK(DMA_OK), .IORDY_OFF_OK(IORDY_OFF_OK)
    ) u_dec (
        .sub(cmd_sub), .count(cmd_count), .dma_active(dma_active), .dec(dec)
    );

    assign accept      = cmd_valid && !busy;
    assign start_flush = accept && dec.ok && (dec.act == ACT_WC_OFF);
    assign apply       = accept && dec.ok && (dec.act != ACT_WC_OFF);

    setfeat_flush_seq u_flush (
        .clk(clk), .rst_n(rst_n), .start(start_flush), .flush_ack(flush_ack),
        .flush_req(flush_req), .busy(busy), .drain_done(drain_done)
    );

    setfeat_state #(.DMA_OK(DMA_OK)) u_state (
        .clk(clk), .rst_n(rst_n), .apply(apply), .dec(dec), .wc_clear(drain_done),
        .xfer8_on(xfer8_on), .wcache_on(wcache_on), .pio_mode(pio_mode),
        .iordy_on(iordy_on), .mdma_on(mdma_on), .udma_on(udma_on),
        .dma_mode(dma_mode), .dma_active(dma_active), .apm_level(apm_level)
    );

    // Register the status pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q  <= apply || drain_done;
            abort_q <= accept && !dec.ok;
        end
    end

    assign cmd_done  = done_q;
    assign cmd_abort = abort_q;
    assign io16_en   = !xfer8_on;

    // R12
    property status_excl_p;
        @(posedge clk) disable iff (!rst_n) !(cmd_done && cmd_abort);
    endproperty
    status_excl_chk: assert property (status_excl_p);

    // R10
    property abort_hold_p;
        @(posedge clk) disable iff (!rst_n)
        cmd_abort |-> ($stable(pio_mode) && $stable(dma_mode) && $stable(apm_level)
                       && $stable(xfer8_on) && $stable(udma_on) && $stable(dma_active)
                       && $stable(iordy_on) && $stable(wcache_on));
    endproperty
    abort_hold_chk: assert property (abort_hold_p);

    // R4
    property wc_fall_p;
        @(posedge clk) disable iff (!rst_n) $fell(wcache_on) |-> cmd_done;
    endproperty
    wc_fall_chk: assert property (wc_fall_p);

    // R11
    property x8_rise_p;
        @(posedge clk) disable iff (!rst_n) $rose(xfer8_on) |-> (cmd_done && !dma_active);
    endproperty
    x8_rise_chk: assert property (x8_rise_p);

endmodule

// File: tb/sim_setfeat_handler.sv
`timescale 1ns/1ps
module sim_setfeat_handler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_sub = 8'h00;
    logic [7:0] cmd_count = 8'h00;
    logic       flush_ack = 1'b0;
    logic       cmd_done, cmd_abort, busy, flush_req, xfer8_on, io16_en, wcache_on;
    logic [2:0] pio_mode, dma_mode;
    logic       iordy_on, mdma_on, udma_on, dma_active;
    logic [7:0] apm_level;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    setfeat_handler u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sub(cmd_sub),
        .cmd_count(cmd_count), .flush_ack(flush_ack), .cmd_done(cmd_done),
        .cmd_abort(cmd_abort), .busy(busy), .flush_req(flush_req),
        .xfer8_on(xfer8_on), .io16_en(io16_en), .wcache_on(wcache_on),
        .pio_mode(pio_mode), .iordy_on(iordy_on), .mdma_on(mdma_on),
        .udma_on(udma_on), .dma_mode(dma_mode), .dma_active(dma_active),
        .apm_level(apm_level)
    );

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] cnt;
        logic       ab;
        logic [2:0] pio;
        logic       iordy;
        logic       mdma;
        logic       udma;
        logic [2:0] dm;
        logic       act;
        logic       x8;
        logic [7:0] apm;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{8'h03, 8'h0C, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd5},  // R5 PIO 4
        '{8'h03, 8'h01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd6},  // R6 IORDY off
        '{8'h03, 8'h0B, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd8},  // R8 forced
        '{8'h03, 8'h0A, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd8},  // R8 below 3
        '{8'h03, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd6},  // R6 default
        '{8'h03, 8'h0D, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFE, 4'd10}, // R10 PIO 5
        '{8'h01, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 8'hFE, 4'd2},  // R2 8-bit on
        '{8'h03, 8'h22, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 8'hFE, 4'd7},  // R7 MDMA 2
        '{8'h81, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b0, 8'hFE, 4'd2},  // R2 8-bit off
        '{8'h01, 8'h00, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b0, 8'hFE, 4'd11}, // R11
        '{8'h03, 8'h45, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFE, 4'd7},  // R7 UDMA 5
        '{8'h03, 8'h46, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFE, 4'd10}, // R10 UDMA 6
        '{8'h03, 8'h23, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFE, 4'd10}, // R10 MDMA 3
        '{8'h03, 8'h10, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFE, 4'd10}, // R10 type 00010b
        '{8'h03, 8'h80, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 8'hFE, 4'd10}, // R10 bit 7 set
        '{8'h03, 8'h21, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 8'hFE, 4'd7},  // R7 back to MDMA
        '{8'h03, 8'h09, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 8'hFE, 4'd5},  // R5 PIO 1
        '{8'h01, 8'h00, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'hFE, 4'd2},  // R2
        '{8'h05, 8'h80, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h80, 4'd9},  // R9
        '{8'h05, 8'h00, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h80, 4'd9},  // R9 00h
        '{8'h05, 8'hFF, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h80, 4'd9},  // R9 FFh
        '{8'h05, 8'h01, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h01, 4'd9},  // R9 01h
        '{8'h55, 8'h00, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h01, 4'd10}, // R10 unknown
        '{8'h03, 8'h02, 1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h01, 4'd10}, // R10 default n=2
        '{8'h02, 8'h00, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 8'h01, 4'd3}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe one command; return at the following negedge, when results show.
    task automatic strobe(input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_sub   = s;
        cmd_count = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pio", 32'(pio_mode), 0);
        chk("R1 iordy", 32'(iordy_on), 1);
        chk("R1 wcache", 32'(wcache_on), 1);
        chk("R1 x8", 32'(xfer8_on), 0);
        chk("R1 io16", 32'(io16_en), 1);
        chk("R1 apm", 32'(apm_level), 32'hFE);
        chk("R1 dma kind", {30'b0, mdma_on, udma_on}, 2);
        chk("R1 dma", {28'b0, dma_mode, dma_active}, 0);
        chk("R1 status", {30'b0, cmd_done, cmd_abort}, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            strobe(TBL[i].sub, TBL[i].cnt);
            chk({tag, " status"}, {30'b0, cmd_done, cmd_abort}, {30'b0, !TBL[i].ab, TBL[i].ab});
            chk({tag, " pio"}, 32'(pio_mode), 32'(TBL[i].pio));
            chk({tag, " iordy"}, 32'(iordy_on), 32'(TBL[i].iordy));
            chk({tag, " kind"}, {30'b0, mdma_on, udma_on}, {30'b0, TBL[i].mdma, TBL[i].udma});
            chk({tag, " dma"}, {28'b0, dma_mode, dma_active}, {28'b0, TBL[i].dm, TBL[i].act});
            chk({tag, " x8"}, {30'b0, xfer8_on, io16_en}, {30'b0, TBL[i].x8, !TBL[i].x8});
            chk({tag, " apm"}, 32'(apm_level), 32'(TBL[i].apm));
            chk({tag, " wcache"}, 32'(wcache_on), 1);
            @(negedge clk);
            // R12 single-cycle pulse
            chk({tag, " R12 pulse"}, {30'b0, cmd_done, cmd_abort}, 0);
        end

        // R4 cache disable with a held write-back
        strobe(8'h82, 8'h00);
        chk("R4 req", {30'b0, flush_req, busy}, 3);
        chk("R4 no done yet", {30'b0, cmd_done, cmd_abort}, 0);
        chk("R4 wcache held", 32'(wcache_on), 1);
        repeat (3) @(negedge clk);
        chk("R4 req stays", {30'b0, flush_req, busy}, 3);
        strobe(8'h05, 8'h40);   // ignored while busy
        chk("R4 ignored status", {30'b0, cmd_done, cmd_abort}, 0);
        chk("R4 ignored apm", 32'(apm_level), 32'h01);
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
        chk("R4 complete", {29'b0, cmd_done, flush_req, busy}, 4);
        chk("R4 wcache off", 32'(wcache_on), 0);
        @(negedge clk);
        chk("R12 flush pulse", {30'b0, cmd_done, cmd_abort}, 0);
        // R3 re-enable
        strobe(8'h02, 8'h00);
        chk("R3 wcache on", {30'b0, wcache_on, cmd_done}, 3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule